// File: doc/BRIEF.md
# Condition Code Flag Unit

This block holds the eight-bit condition code register of a processor datapath. The flags change only on a clock edge. The data ALU reports each result to the block: the result word, the carry or borrow out of its top bit, an overflow indication, a class code for the operation, and four extra flag values. A separate address-generation path can also report a result. When it does, it sets the four arithmetic flags in place of the ALU. Each flag has its own update enable, so an instruction can choose which flags it changes.

The operation class sets which flags a result may change:

- Integer and fixed-point operations write carry, overflow, zero and negative.
- Floating-point operations never touch carry. They write overflow only when they produce a fixed-point result.
- Bus transfers and idle cycles leave every flag as it was.

The arithmetic that produces the inputs is outside this block. So is the floating-point meaning of the four extra flags.

Top module: `cond_flag_reg`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears all eight flags. The flag vector bit order is: bit 0 carry, bit 1 overflow, bit 2 zero, bit 3 negative, bit 4 infinity, bit 5 local reject, bit 6 reject, bit 7 accept.
- R2: On an integer operation (op_class 2'b01) with the carry enable set, carry takes the value of carry_in one clock later.
- R3: On an integer operation with its enable set, overflow takes ovf_in. On a floating-point operation (op_class 2'b10), overflow takes ovf_in only when fix_res is high; otherwise it holds.
- R4: A floating-point operation never changes carry, whatever its enable or carry_in.
- R5: On an integer or floating-point operation, zero is set exactly when every bit of res_word is 0, and negative takes the top bit of res_word. Each applies only when its enable is set.
- R6: On an integer or floating-point operation, flags 4 to 7 take ext_flags bits 0 to 3, each under its own enable.
- R7: A bus-transfer cycle (op_class 2'b11) or an idle cycle (op_class 2'b00) changes no flag.
- R8: A flag whose upd_en bit is low keeps its value. With upd_en all zero the whole vector holds.
- R9: When agu_valid is high, the address path overrides the data ALU inputs for the four arithmetic flags, whatever the op_class. Carry takes agu_carry, overflow takes agu_ovf, zero is set when agu_res is all zero, and negative takes the top bit of agu_res. Flags 4 to 7 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 2 | 00 idle, 01 integer/fixed-point, 10 floating-point, 11 bus transfer |
| res_word | input | DATA_W | Data ALU result |
| carry_in | input | 1 | Carry or borrow out of the result top bit |
| ovf_in | input | 1 | Result not representable in the destination size |
| fix_res | input | 1 | Floating-point operation produced a fixed-point result |
| ext_flags | input | 4 | New values for flags 4 to 7 |
| agu_valid | input | 1 | Address-transfer move updates the arithmetic flags |
| agu_carry | input | 1 | Address-path carry |
| agu_ovf | input | 1 | Address-path overflow |
| agu_res | input | AGU_W | Address-path result |
| upd_en | input | 8 | Per-flag update enable, same bit order as flags |
| flags | output | 8 | Condition code register |

## Verification
The bench builds the block with DATA_W of 16, AGU_W of 8 and the chunked zero detector using 4-bit chunks. At these sizes a walking single-bit result passes through every chunk of the zero tree, including the chunk that holds the sign bit. The narrow address width also makes it cheap to hit its top bit, so the negative flag can be driven from either source. The vector table covers every operation class with full and partial enable masks, and an address-path override that arrives together with an integer result.

// File: rtl/cflag_pkg.sv
package cflag_pkg;

   localparam int NUM_FLAGS = 8;
   localparam int NUM_EXT   = 4;

   localparam int FB_C  = 0;
   localparam int FB_V  = 1;
   localparam int FB_Z  = 2;
   localparam int FB_N  = 3;
   localparam int FB_X0 = 4;

   typedef enum logic [1:0] {
      OPC_IDLE = 2'b00,
      OPC_INT  = 2'b01,
      OPC_FLT  = 2'b10,
      OPC_BUS  = 2'b11
   } op_class_e;

endpackage

// File: rtl/cf_zero_det.sv
module cf_zero_det #(
   parameter int W     = 32,
   parameter bit TREE  = 1'b1,
   parameter int CHUNK = 8
) (
   input  logic [W-1:0] din,
   output logic         is_zero
);
   localparam int NCH = (W + CHUNK - 1) / CHUNK;

   generate
      if (W < 1) begin : g_bad_w
         $error("cf_zero_det: W must be at least 1");
      end
      if (CHUNK < 1) begin : g_bad_chunk
         $error("cf_zero_det: CHUNK must be at least 1");
      end

      if (TREE) begin : g_tree
         logic [NCH-1:0] chunk_any;
         for (genvar g = 0; g < NCH; g++) begin : g_chunk
            localparam int LO = g * CHUNK;
            localparam int HI = (LO + CHUNK - 1 > W - 1) ? W - 1 : LO + CHUNK - 1;
            assign chunk_any[g] = |din[HI:LO];
         end
         assign is_zero = ~(|chunk_any);
      end else begin : g_flat
         assign is_zero = ~(|din);
      end
   endgenerate
endmodule

// File: rtl/cf_src_mux.sv
module cf_src_mux
   import cflag_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AGU_W  = 16
) (
   input  logic [1:0]           op_class,
   input  logic                 res_zero,
   input  logic                 res_msb,
   input  logic                 carry_in,
   input  logic                 ovf_in,
   input  logic                 fix_res,
   input  logic [NUM_EXT-1:0]   ext_flags,
   input  logic                 agu_valid,
   input  logic                 agu_carry,
   input  logic                 agu_ovf,
   input  logic                 agu_zero,
   input  logic                 agu_msb,
   input  logic [NUM_FLAGS-1:0] upd_en,
   output logic [NUM_FLAGS-1:0] wr,
   output logic [NUM_FLAGS-1:0] nxt
);
   op_class_e cls;
   logic      alu_op;
   logic      is_int;
   logic      is_flt;
   logic [NUM_FLAGS-1:0] may_wr;

   always_comb begin
      cls    = op_class_e'(op_class);
      is_int = (cls == OPC_INT);
      is_flt = (cls == OPC_FLT);
      alu_op = is_int || is_flt;

      may_wr = '0;
      nxt    = '0;

      if (agu_valid) begin
         may_wr[FB_C] = 1'b1;
         may_wr[FB_V] = 1'b1;
         may_wr[FB_Z] = 1'b1;
         may_wr[FB_N] = 1'b1;
         nxt[FB_C]    = agu_carry;
         nxt[FB_V]    = agu_ovf;
         nxt[FB_Z]    = agu_zero;
         nxt[FB_N]    = agu_msb;
      end else begin
         may_wr[FB_C] = is_int;
         may_wr[FB_V] = is_int || (is_flt && fix_res);
         may_wr[FB_Z] = alu_op;
         may_wr[FB_N] = alu_op;
         nxt[FB_C]    = carry_in;
         nxt[FB_V]    = ovf_in;
         nxt[FB_Z]    = res_zero;
         nxt[FB_N]    = res_msb;
         for (int k = 0; k < NUM_EXT; k++) begin
            may_wr[FB_X0+k] = alu_op;
            nxt[FB_X0+k]    = ext_flags[k];
         end
      end

      wr = may_wr & upd_en;
   end
endmodule

// File: rtl/cf_flag_bit.sv
module cf_flag_bit #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (wr) q <= d;
   end
endmodule

// File: rtl/cond_flag_reg.sv
module cond_flag_reg
   import cflag_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int AGU_W      = 16,
   parameter bit ZDET_TREE  = 1'b1,
   parameter int ZDET_CHUNK = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_class,
   input  logic [DATA_W-1:0] res_word,
   input  logic              carry_in,
   input  logic              ovf_in,
   input  logic              fix_res,
   input  logic [3:0]        ext_flags,
   input  logic              agu_valid,
   input  logic              agu_carry,
   input  logic              agu_ovf,
   input  logic [AGU_W-1:0]  agu_res,
   input  logic [7:0]        upd_en,
   output logic [7:0]        flags
);
   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("cond_flag_reg: DATA_W must be at least 2");
      end
      if (AGU_W < 2) begin : g_bad_agu_w
         $error("cond_flag_reg: AGU_W must be at least 2");
      end
      if (ZDET_CHUNK < 1) begin : g_bad_chunk
         $error("cond_flag_reg: ZDET_CHUNK must be at least 1");
      end
   endgenerate

   logic                 res_zero;
   logic                 agu_zero;
   logic [NUM_FLAGS-1:0] wr;
   logic [NUM_FLAGS-1:0] nxt;

   cf_zero_det #(.W(DATA_W), .TREE(ZDET_TREE), .CHUNK(ZDET_CHUNK)) u_zdet_res (
      .din     (res_word),
      .is_zero (res_zero)
   );

   cf_zero_det #(.W(AGU_W), .TREE(ZDET_TREE), .CHUNK(ZDET_CHUNK)) u_zdet_agu (
      .din     (agu_res),
      .is_zero (agu_zero)
   );

   cf_src_mux #(.DATA_W(DATA_W), .AGU_W(AGU_W)) u_mux (
      .op_class  (op_class),
      .res_zero  (res_zero),
      .res_msb   (res_word[DATA_W-1]),
      .carry_in  (carry_in),
      .ovf_in    (ovf_in),
      .fix_res   (fix_res),
      .ext_flags (ext_flags),
      .agu_valid (agu_valid),
      .agu_carry (agu_carry),
      .agu_ovf   (agu_ovf),
      .agu_zero  (agu_zero),
      .agu_msb   (agu_res[AGU_W-1]),
      .upd_en    (upd_en),
      .wr        (wr),
      .nxt       (nxt)
   );

   generate
      for (genvar b = 0; b < NUM_FLAGS; b++) begin : g_flag
         cf_flag_bit #(.RST_VAL(1'b0)) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr[b]),
            .d     (nxt[b]),
            .q     (flags[b])
         );
      end
   endgenerate
endmodule

// File: rtl/cond_flag_reg_chk.sv
module cond_flag_reg_chk #(
   parameter int DATA_W = 32,
   parameter int AGU_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        op_class,
   input logic [DATA_W-1:0] res_word,
   input logic              carry_in,
   input logic              fix_res,
   input logic              agu_valid,
   input logic [7:0]        upd_en,
   input logic [7:0]        flags
);
   assert_int_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!agu_valid && op_class == 2'b01 && upd_en[0]) |=> flags[0] == $past(carry_in));

   assert_flt_ovf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!agu_valid && op_class == 2'b10 && !fix_res) |=> flags[1] == $past(flags[1]));

   assert_flt_carry_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!agu_valid && op_class == 2'b10) |=> flags[0] == $past(flags[0]));

   assert_int_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!agu_valid && op_class == 2'b01 && upd_en[2]) |=> flags[2] == ($past(res_word) == '0));

   assert_bus_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!agu_valid && (op_class == 2'b11 || op_class == 2'b00)) |=> flags == $past(flags));

   assert_no_enable_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en == 8'h00) |=> flags == $past(flags));

   assert_agu_extra_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      agu_valid |=> flags[7:4] == $past(flags[7:4]));
endmodule

bind cond_flag_reg cond_flag_reg_chk #(.DATA_W(DATA_W), .AGU_W(AGU_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_class  (op_class),
   .res_word  (res_word),
   .carry_in  (carry_in),
   .fix_res   (fix_res),
   .agu_valid (agu_valid),
   .upd_en    (upd_en),
   .flags     (flags)
);

// File: tb/cond_flag_reg_bench.sv
`timescale 1ns/1ps
module cond_flag_reg_bench;
   localparam int DW = 16;
   localparam int AW = 8;

   typedef struct packed {
      logic [1:0]  cls;
      logic [15:0] res;
      logic        cy;
      logic        ov;
      logic        fx;
      logic [3:0]  ext;
      logic        ag;
      logic        agc;
      logic        agv;
      logic [7:0]  agr;
      logic [7:0]  en;
      logic [7:0]  exp;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{2'd1, 16'h0000, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h05}, // R2 R5
      '{2'd1, 16'h8001, 1'b1, 1'b1, 1'b0, 4'h5, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h5B}, // R3 R5 R6
      '{2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h07}, // R4 R3
      '{2'd2, 16'h4000, 1'b0, 1'b0, 1'b1, 4'h8, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h81}, // R3 R6
      '{2'd3, 16'h0000, 1'b0, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h81}, // R7 bus
      '{2'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h81}, // R7 idle
      '{2'd1, 16'hFFFF, 1'b0, 1'b1, 1'b0, 4'h6, 1'b0, 1'b0, 1'b0, 8'h00, 8'h02, 8'h83}, // R8 only V
      '{2'd1, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h83}, // R8 none
      '{2'd1, 16'h0000, 1'b1, 1'b1, 1'b0, 4'hF, 1'b1, 1'b0, 1'b0, 8'h80, 8'hFF, 8'h88}, // R9 override
      '{2'd3, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 8'h87}, // R9 on bus
      '{2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h01, 8'h87}, // R4
      '{2'd1, 16'h0001, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hF0, 8'h07}  // R6 R8
   };
   localparam int VREQ [NV] = '{2, 3, 4, 3, 7, 7, 8, 8, 9, 9, 4, 6};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    op_class = 2'b00;
   logic [DW-1:0] res_word = '0;
   logic          carry_in = 1'b0;
   logic          ovf_in = 1'b0;
   logic          fix_res = 1'b0;
   logic [3:0]    ext_flags = 4'h0;
   logic          agu_valid = 1'b0;
   logic          agu_carry = 1'b0;
   logic          agu_ovf = 1'b0;
   logic [AW-1:0] agu_res = '0;
   logic [7:0]    upd_en = 8'h00;
   logic [7:0]    flags;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   cond_flag_reg #(.DATA_W(DW), .AGU_W(AW), .ZDET_TREE(1'b1), .ZDET_CHUNK(4)) u_cond_flag_reg (
      .clk(clk), .rst_n(rst_n), .op_class(op_class), .res_word(res_word),
      .carry_in(carry_in), .ovf_in(ovf_in), .fix_res(fix_res), .ext_flags(ext_flags),
      .agu_valid(agu_valid), .agu_carry(agu_carry), .agu_ovf(agu_ovf), .agu_res(agu_res),
      .upd_en(upd_en), .flags(flags)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: flags actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      op_class  = v.cls;
      res_word  = v.res;
      carry_in  = v.cy;
      ovf_in    = v.ov;
      fix_res   = v.fx;
      ext_flags = v.ext;
      agu_valid = v.ag;
      agu_carry = v.agc;
      agu_ovf   = v.agv;
      agu_res   = v.agr;
      upd_en    = v.en;
   endtask

   initial begin
      vec_t v;
      logic [7:0] expv;
      repeat (3) @(negedge clk);
      check("R1", flags, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", flags, 8'h00);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i]);
         @(negedge clk);
         check($sformatf("R%0d (vector %0d)", VREQ[i], i), flags, VEC[i].exp);
      end

      // R5: walking single bit through every zero-detect chunk, Z and N only
      for (int b = 0; b < DW; b++) begin
         v = '{2'd1, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h0C, 8'h00};
         v.res = 16'h0001 << b;
         drive(v);
         @(negedge clk);
         expv = {4'h0, (b == DW - 1), 1'b0, 2'b11};
         check("R5 walking bit", flags, expv);
      end
      v = '{2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h0C, 8'h00};
      drive(v);
      @(negedge clk);
      check("R5 zero result", flags, 8'h07);

      // R9: address-path negative from its top bit, zero cleared
      v = '{2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 8'hC0, 8'hFF, 8'h00};
      drive(v);
      @(negedge clk);
      check("R9 agu msb", flags, 8'h0A);

      // R1: asynchronous reset while flags are set
      v = '{2'd1, 16'h8000, 1'b1, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h00};
      drive(v);
      @(negedge clk);
      check("R1 pre-reset load", flags, 8'hFB);
      #1 rst_n = 1'b0;
      #1 check("R1 async clear", flags, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      upd_en = 8'h00;
      @(negedge clk);
      check("R1 after release", flags, 8'h00);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule